// File: doc/BRIEF.md
# DMA Channel Ring Pointer Registers with Coalesced Interrupt

This block holds the four ring indices of one DMA channel: the head and tail of a request ring, and the head and tail of a response ring. The rings live in host memory and are not modelled here. The host reaches the indices through a small register window. It moves the request tail forward to submit work, and it moves the response head forward as it consumes completions. Device-side logic steps the request head as it takes requests and steps the response tail as it posts responses. Each step is guarded so that neither ring can be overrun.

An interrupt pulse is raised only when the response ring turns from empty to non-empty. Further postings into a ring that is already non-empty raise nothing, so one interrupt stands for a whole burst of completions. A separate forced-interrupt control can raise a pulse at any time when it is enabled.

Indices count modulo a power-of-two ring depth. A ring is empty when head equals tail. The response ring is full when the tail is one slot behind the head.

Top module: `dma_ring_regs`

## Requirements
- R1: The register window maps request head at offset 0x0, request tail at 0x4, response head at 0x8 and response tail at 0xC. A read returns the addressed index zero-extended to DATA_W bits, combinationally from `reg_addr`.
- R2: After reset all four indices read zero, `irq` is low, `req_avail` is low and `rsp_full` is low.
- R3: A host write to 0x4 or 0x8 stores the written value modulo DEPTH. The new value is readable from the cycle after the write edge.
- R4: Host writes to 0x0 and 0xC leave every index unchanged.
- R5: Reads of any offset in the window other than 0x0, 0x4, 0x8 and 0xC return zero.
- R6: When the request ring is non-empty, `req_consume` advances the request head by one modulo DEPTH. When the ring is empty (head equals tail), `req_consume` is ignored.
- R7: When the response ring is not full, `rsp_post` advances the response tail by one modulo DEPTH. The ring is full when (tail+1) mod DEPTH equals head, and in that case `rsp_post` is ignored.
- R8: `irq` is high for exactly the one cycle after a clock edge at which the response ring goes from empty to non-empty.
- R9: No `irq` pulse is raised while the response ring stays non-empty, or when it goes from non-empty to empty, unless a forced interrupt is requested.
- R10: With `force_en` high, a `force_trig` cycle raises `irq` in the next cycle whatever the ring occupancy. With `force_en` low, `force_trig` has no effect.
- R11: `req_avail` is high exactly when the request head differs from the request tail. `rsp_full` is high exactly when the response ring is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wen | input | 1 | Host register write strobe |
| reg_addr | input | ADDR_W | Byte offset within the channel window |
| reg_wdata | input | DATA_W | Host write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr` |
| req_consume | input | 1 | Device has taken one request entry |
| rsp_post | input | 1 | Device has posted one response entry |
| force_en | input | 1 | Enables the forced interrupt |
| force_trig | input | 1 | Requests a forced interrupt |
| req_avail | output | 1 | Request ring holds entries |
| rsp_full | output | 1 | Response ring is full |
| irq | output | 1 | Single-cycle interrupt pulse |

## Verification
Several properties are checked by assertions on every cycle: consume and post requests that arrive against an empty or full ring leave the indices stable, a posting into an empty ring is followed by a pulse, no pulse appears while the ring stays occupied without a force, and writes to the device-owned offsets do not move them. Other behaviour can only be shown by the bench's scenarios, because it depends on what the host sees: the modulo masking of written values, wrap-around of the request head past the top of the ring, zero reads from unmapped offsets, and the exact cycle in which each interrupt pulse appears. The bench checks those pulse cycles against a queue of expected pulses.

// File: rtl/ring_pkg.sv
package ring_pkg;
   // Byte offsets of the channel registers inside the window
   localparam int unsigned OFS_REQ_HEAD = 32'h0;
   localparam int unsigned OFS_REQ_TAIL = 32'h4;
   localparam int unsigned OFS_RSP_HEAD = 32'h8;
   localparam int unsigned OFS_RSP_TAIL = 32'hC;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_REQ_HEAD,
      SEL_REQ_TAIL,
      SEL_RSP_HEAD,
      SEL_RSP_TAIL
   } reg_sel_e;
endpackage

// File: rtl/ring_ptr.sv
module ring_ptr #(
   parameter int unsigned IDX_W      = 4,
   parameter bit          HOST_OWNED = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             host_we,
   input  logic [IDX_W-1:0] host_wdata,
   input  logic             dev_step,
   output logic [IDX_W-1:0] ptr_q
);
   generate
      if (HOST_OWNED) begin : g_host
         // Host-owned index: loaded only by the register bus
         logic unused_step;
         assign unused_step = dev_step;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       ptr_q <= '0;
            else if (host_we) ptr_q <= host_wdata;
         end
      end else begin : g_dev
         // Device-owned index: steps by one, wrapping at the power-of-two depth
         logic unused_host;
         assign unused_host = host_we ^ (^host_wdata);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        ptr_q <= '0;
            else if (dev_step) ptr_q <= ptr_q + 1'b1;
         end

         // The bus can never move a device-owned index (R4)
         assert_dev_ptr_bus_blind_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (host_we && !dev_step) |=> $stable(ptr_q));
      end
   endgenerate
endmodule

// File: rtl/irq_coalesce.sv
module irq_coalesce (
   input  logic clk,
   input  logic rst_n,
   input  logic empty_now,
   input  logic empty_next,
   input  logic force_en,
   input  logic force_trig,
   output logic irq_o
);
   logic fire;

   // Pulse on the empty to non-empty edge only, or on an enabled force
   always_comb fire = (empty_now && !empty_next) || (force_en && force_trig);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_o <= 1'b0;
      else        irq_o <= fire;
   end

   assert_no_irq_while_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!empty_now && !(force_en && force_trig)) |=> !irq_o);

   assert_force_fires_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (force_en && force_trig) |=> irq_o);
endmodule

// File: rtl/dma_ring_regs.sv
module dma_ring_regs
   import ring_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 5,
   parameter int unsigned DEPTH  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wen,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              req_consume,
   input  logic              rsp_post,
   input  logic              force_en,
   input  logic              force_trig,
   output logic              req_avail,
   output logic              rsp_full,
   output logic              irq
);
   localparam int unsigned IDX_W = (DEPTH > 2) ? $clog2(DEPTH) : 1;

   // Elaboration-time parameter checks
   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("DEPTH must be a power of two of at least 2");
      end
      if (DATA_W <= IDX_W) begin : g_bad_width
         $error("DATA_W must be wider than the ring index");
      end
      if (ADDR_W < 4) begin : g_bad_addr
         $error("ADDR_W must cover offsets 0x0 to 0xC");
      end
   endgenerate

   reg_sel_e         sel;
   logic [IDX_W-1:0] wr_idx;
   logic [IDX_W-1:0] req_head, req_tail, rsp_head, rsp_tail;
   logic [IDX_W-1:0] rsp_head_nx, rsp_tail_nx;
   logic             req_tail_we, rsp_head_we;
   logic             req_step, rsp_step;
   logic             req_empty, rsp_empty, rsp_empty_nx;
   logic             unused_wdata_hi;

   // Offset decode
   always_comb begin
      unique case (reg_addr)
         ADDR_W'(OFS_REQ_HEAD): sel = SEL_REQ_HEAD;
         ADDR_W'(OFS_REQ_TAIL): sel = SEL_REQ_TAIL;
         ADDR_W'(OFS_RSP_HEAD): sel = SEL_RSP_HEAD;
         ADDR_W'(OFS_RSP_TAIL): sel = SEL_RSP_TAIL;
         default:               sel = SEL_NONE;
      endcase
   end

   assign wr_idx          = reg_wdata[IDX_W-1:0];
   assign unused_wdata_hi = |reg_wdata[DATA_W-1:IDX_W];
   assign req_tail_we     = reg_wen && (sel == SEL_REQ_TAIL);
   assign rsp_head_we     = reg_wen && (sel == SEL_RSP_HEAD);

   // Occupancy and guarded device steps
   assign req_empty = (req_head == req_tail);
   assign rsp_empty = (rsp_head == rsp_tail);
   assign rsp_full  = ((rsp_tail + 1'b1) == rsp_head);
   assign req_avail = !req_empty;
   assign req_step  = req_consume && !req_empty;
   assign rsp_step  = rsp_post && !rsp_full;

   assign rsp_head_nx  = rsp_head_we ? wr_idx : rsp_head;
   assign rsp_tail_nx  = rsp_step ? (rsp_tail + 1'b1) : rsp_tail;
   assign rsp_empty_nx = (rsp_head_nx == rsp_tail_nx);

   ring_ptr #(.IDX_W(IDX_W), .HOST_OWNED(1'b0)) u_req_head (
      .clk(clk), .rst_n(rst_n), .host_we(reg_wen && (sel == SEL_REQ_HEAD)),
      .host_wdata(wr_idx), .dev_step(req_step), .ptr_q(req_head));

   ring_ptr #(.IDX_W(IDX_W), .HOST_OWNED(1'b1)) u_req_tail (
      .clk(clk), .rst_n(rst_n), .host_we(req_tail_we),
      .host_wdata(wr_idx), .dev_step(1'b0), .ptr_q(req_tail));

   ring_ptr #(.IDX_W(IDX_W), .HOST_OWNED(1'b1)) u_rsp_head (
      .clk(clk), .rst_n(rst_n), .host_we(rsp_head_we),
      .host_wdata(wr_idx), .dev_step(1'b0), .ptr_q(rsp_head));

   ring_ptr #(.IDX_W(IDX_W), .HOST_OWNED(1'b0)) u_rsp_tail (
      .clk(clk), .rst_n(rst_n), .host_we(reg_wen && (sel == SEL_RSP_TAIL)),
      .host_wdata(wr_idx), .dev_step(rsp_step), .ptr_q(rsp_tail));

   irq_coalesce u_irq (
      .clk(clk), .rst_n(rst_n), .empty_now(rsp_empty), .empty_next(rsp_empty_nx),
      .force_en(force_en), .force_trig(force_trig), .irq_o(irq));

   // Read mux, zero-extended index
   always_comb begin
      reg_rdata = '0;
      unique case (sel)
         SEL_REQ_HEAD: reg_rdata = DATA_W'(req_head);
         SEL_REQ_TAIL: reg_rdata = DATA_W'(req_tail);
         SEL_RSP_HEAD: reg_rdata = DATA_W'(rsp_head);
         SEL_RSP_TAIL: reg_rdata = DATA_W'(rsp_tail);
         default:      reg_rdata = '0;
      endcase
   end

   assert_no_underrun_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_consume && req_avail == 1'b0) |=> $stable(req_head));

   assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_post && rsp_full) |=> $stable(rsp_tail));

   assert_irq_on_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_empty && rsp_post && !rsp_head_we) |=> irq);

   assert_unmapped_read_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr[1:0] != 2'b00) |-> (reg_rdata == '0));
endmodule

// File: tb/dma_ring_regs_tb_top.sv
module dma_ring_regs_tb_top;
   localparam int CLK_P  = 10;
   localparam int DATA_W = 32;
   localparam int ADDR_W = 5;
   localparam int DEPTH  = 8;

   typedef struct {
      int    cyc;
      string tag;
   } irq_item_t;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              reg_wen = 1'b0;
   logic [ADDR_W-1:0] reg_addr = '0;
   logic [DATA_W-1:0] reg_wdata = '0;
   logic [DATA_W-1:0] reg_rdata;
   logic              req_consume = 1'b0, rsp_post = 1'b0;
   logic              force_en = 1'b0, force_trig = 1'b0;
   logic              req_avail, rsp_full, irq;

   int        n_cmp = 0, n_bad = 0, cyc = 0;
   bit        mon_on = 1'b0, done = 1'b0;
   irq_item_t exp_q[$];

   always #(CLK_P/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   dma_ring_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH)) dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_consume(req_consume),
      .rsp_post(rsp_post), .force_en(force_en), .force_trig(force_trig),
      .req_avail(req_avail), .rsp_full(rsp_full), .irq(irq));

   task automatic chk(string tag, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // Monitor: compares irq to the scoreboard on every cycle
   always @(negedge clk) begin
      if (mon_on) begin
         logic  want;
         string tag;
         want = 1'b0;
         tag  = "R9 no pulse";
         if (exp_q.size() > 0 && exp_q[0].cyc == cyc) begin
            want = 1'b1;
            tag  = exp_q[0].tag;
            void'(exp_q.pop_front());
         end
         chk(tag, {31'b0, irq}, {31'b0, want});
      end
   end

   task automatic host_wr(int addr, int data);
      @(negedge clk);
      reg_wen = 1'b1; reg_addr = ADDR_W'(addr); reg_wdata = DATA_W'(data);
      @(negedge clk);
      reg_wen = 1'b0;
   endtask

   task automatic rd_chk(int addr, int exp, string tag);
      @(negedge clk);
      reg_addr = ADDR_W'(addr);
      #1 chk(tag, reg_rdata, DATA_W'(exp));
   endtask

   task automatic consume();
      @(negedge clk); req_consume = 1'b1;
      @(negedge clk); req_consume = 1'b0;
   endtask

   task automatic post(bit want_irq, string tag);
      @(negedge clk); rsp_post = 1'b1;
      if (want_irq) exp_q.push_back('{cyc + 1, tag});
      @(negedge clk); rsp_post = 1'b0;
   endtask

   initial begin
      #(CLK_P * 20000);
      if (!done) begin
         n_bad++; n_cmp++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      mon_on = 1'b1;
      // R2: reset state
      rd_chk(0, 0, "R2 req head"); rd_chk(4, 0, "R2 req tail");
      rd_chk(8, 0, "R2 rsp head"); rd_chk(12, 0, "R2 rsp tail");
      chk("R2 req_avail", {31'b0, req_avail}, 0);
      chk("R2 rsp_full", {31'b0, rsp_full}, 0);

      // R3 and R1: host-owned request tail, masked modulo DEPTH
      host_wr(4, 5);  rd_chk(4, 5, "R3 R1 req tail");
      host_wr(4, 11); rd_chk(4, 3, "R3 modulo");
      chk("R11 req_avail set", {31'b0, req_avail}, 1);

      // R6: consume up to the tail, then an ignored consume
      repeat (3) consume();
      rd_chk(0, 3, "R6 head reached tail");
      consume();
      rd_chk(0, 3, "R6 consume on empty ignored");
      chk("R11 req_avail clear", {31'b0, req_avail}, 0);
      host_wr(4, 1);
      repeat (6) consume();
      rd_chk(0, 1, "R6 head wraps");

      // R4: writes to device-owned offsets ignored
      host_wr(0, 7);  rd_chk(0, 1, "R4 req head write");
      host_wr(12, 4); rd_chk(12, 0, "R4 rsp tail write");
      // R5: unmapped offsets read zero
      rd_chk(16, 0, "R5 offset 0x10"); rd_chk(2, 0, "R5 offset 0x2");

      // R8/R9: coalescing
      post(1'b1, "R8 first post");
      post(1'b0, "R9");
      rd_chk(12, 2, "R7 rsp tail two");
      host_wr(8, 2); rd_chk(8, 2, "R3 rsp head");
      post(1'b1, "R8 refill after drain");
      repeat (6) post(1'b0, "R9");
      rd_chk(12, 1, "R7 tail at full");
      chk("R11 rsp_full", {31'b0, rsp_full}, 1);
      post(1'b0, "R9");
      rd_chk(12, 1, "R7 post on full ignored");

      // R10: forced interrupt
      @(negedge clk); force_trig = 1'b1;
      @(negedge clk); force_trig = 1'b0;
      @(negedge clk); force_en = 1'b1; force_trig = 1'b1;
      exp_q.push_back('{cyc + 1, "R10 forced"});
      @(negedge clk); force_trig = 1'b0; force_en = 1'b0;
      repeat (3) @(negedge clk);
      chk("R8 scoreboard drained", exp_q.size(), 0);

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule